// File: doc/BRIEF.md
# Paced Multichannel DAC FIFO Controller

This block sits between a byte-wide host register port and a four-channel, 12-bit digital-to-analog converter bank. The host builds each 12-bit sample from two byte writes. A write to the low-sample register latches the four least-significant bits. A write to the high-sample register supplies the upper eight bits and completes the sample. Completed samples are queued in a 1024-entry FIFO. An external pacer tick then drains the FIFO through a contiguous channel window: every tick updates the channels from the first channel to the last channel of the window in ascending order, one channel per clock, and each channel takes the next sample in the queue.

The host arms pacing by filling the FIFO completely. When the fill level drops to half, the block flags an interrupt so the host can top the queue up in blocks. A direct mode bypasses the queue: each completed sample goes straight to the first channel of the window. Two register reads have side effects. One read acknowledges the interrupt and another flushes the FIFO.

Top module: `dac_pacer_fifo_ctrl`

## Requirements
- R1: A sample equals {high-register write data[7:0], low-register data[3:0]}, where the low part is the value most recently written to offset 0. The completed sample is taken on the offset 1 write and appears unchanged on `dac_data` when it is loaded.
- R2: With the hold bit clear, an offset 1 write pushes the sample into the FIFO. Pacer ticks produce no DAC loads until the write that brings the FIFO to 1024 entries has occurred.
- R3: Once armed, each accepted tick makes the block load channels first..last in ascending order, one per clock starting the clock after the tick. Each channel takes the next sample in FIFO order, and `dac_load` is one-hot for one cycle. Ticks that arrive while a scan is still running are ignored.
- R4: The window is offset 2: last channel in bits 5:4 and first channel in bits 1:0. If last equals first, one channel is loaded per tick. If last is below first, only the first channel is loaded.
- R5: With the hold bit (offset 3 bit 0) set, an offset 1 write loads the sample onto the first channel in the following cycle and leaves the FIFO unchanged. Pacer ticks cause no loads, and setting the bit disarms pacing.
- R6: Offset 2 reads back with the last channel in bits 5:4, the first channel in bits 1:0, and zeros elsewhere.
- R7: Offset 3 reads as {int-enable, level[2:0], empty, half, error, int-pending} from bit 7 down to bit 0. Half is set when 512 or more entries are held. Int-enable, level and hold are written through bits 7, 6:4 and 0. Offsets 0 and 1 read as zero.
- R8: Int-pending sets when a pop brings the fill level from 513 to 512. A read of offset 0 clears it. `irq` equals int-pending AND int-enable.
- R9: A read of offset 1 empties the FIFO, clears the error flag and disarms pacing.
- R10: The error flag sets on a push into a full FIFO (the sample is dropped) or on a scan pop from an empty FIFO (that channel gets no load). It stays set until the FIFO is flushed.
- R11: After reset, all registers are zero, the FIFO is empty (offset 3 reads 0x08), and `dac_load` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access (side effects at the clock edge) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed offset |
| pacer_tick | input | 1 | Pacer event, one cycle wide |
| dac_load | output | 4 | Per-channel load strobe, one-hot |
| dac_data | output | 12 | Sample for the strobed channel |
| irq | output | 1 | Half-empty interrupt request |

## Verification
The assertions assume that the host never raises read and write in the same cycle. They also assume that a direct write never arrives during a running scan, since the block drops it in that case. The sticky-error and flush checks further assume that reset is the only other path that clears state. The stimulus keeps to these limits: every access is a single-cycle strobe followed by an idle cycle, the hold bit is changed only when the scan is idle, and ticks are single pulses except in one deliberate back-to-back case that tests how ticks are ignored during a scan.

// File: rtl/dac_pacer_pkg.sv
`timescale 1ns/1ps
package dac_pacer_pkg;

    // Register offsets; the byte split of a sample relies on this order.
    typedef enum logic [1:0] {
        OFS_LSB  = 2'd0,
        OFS_MSB  = 2'd1,
        OFS_CHAN = 2'd2,
        OFS_CTRL = 2'd3
    } reg_ofs_e;

    // Bit positions inside the window register.
    localparam int CHAN_LAST_POS  = 4;
    localparam int CHAN_FIRST_POS = 0;

    // Bit positions inside the control/status register.
    localparam int CTRL_INTE_POS = 7;
    localparam int CTRL_LVL_POS  = 4;
    localparam int CTRL_HOLD_POS = 0;

endpackage

// File: rtl/dac_sample_fifo.sv
`timescale 1ns/1ps
module dac_sample_fifo #(
    parameter int DEPTH = 1024,
    parameter int DW    = 12,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          half,
    output logic          err,
    output logic          half_evt,
    output logic          fill_evt
);

    localparam int AW   = $clog2(DEPTH);
    localparam int HALF = DEPTH / 2;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        logic          err;
    } fifo_st_t;

    fifo_st_t s_q, s_d;
    logic [DW-1:0] mem [DEPTH];
    logic push_ok, pop_ok;

    always_comb begin
        s_d      = s_q;
        push_ok  = push && (s_q.cnt < CW'(DEPTH));
        pop_ok   = pop && (s_q.cnt != '0);
        half_evt = 1'b0;
        fill_evt = 1'b0;
        if (clr) begin
            s_d = '0;
        end else begin
            if (push_ok) s_d.wp = s_q.wp + AW'(1);
            if (pop_ok)  s_d.rp = s_q.rp + AW'(1);
            case ({push_ok, pop_ok})
                2'b10:   s_d.cnt = s_q.cnt + CW'(1);
                2'b01:   s_d.cnt = s_q.cnt - CW'(1);
                default: s_d.cnt = s_q.cnt;
            endcase
            s_d.err  = s_q.err | (push && !push_ok) | (pop && !pop_ok);
            half_evt = (s_q.cnt > CW'(HALF)) && (s_d.cnt == CW'(HALF));
            fill_evt = push_ok && (s_q.cnt == CW'(DEPTH - 1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok && !clr) mem[s_q.wp] <= push_data;
    end

    assign head  = mem[s_q.rp];
    assign count = s_q.cnt;
    assign empty = (s_q.cnt == '0);
    assign half  = (s_q.cnt >= CW'(HALF));
    assign err   = s_q.err;

endmodule

// File: rtl/dac_scan_seq.sv
`timescale 1ns/1ps
module dac_scan_seq #(
    parameter int NCH = 4,
    parameter int DW  = 12,
    parameter int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           hold,
    input  logic           arm_evt,
    input  logic           disarm,
    input  logic [CHW-1:0] first_ch,
    input  logic [CHW-1:0] last_ch,
    input  logic           fifo_empty,
    input  logic [DW-1:0]  fifo_head,
    input  logic           direct_wr,
    input  logic [DW-1:0]  direct_data,
    output logic           pop,
    output logic           busy,
    output logic [NCH-1:0] dac_load,
    output logic [DW-1:0]  dac_data
);

    typedef struct packed {
        logic           armed;
        logic           active;
        logic [CHW-1:0] ch;
        logic [CHW-1:0] last;
        logic [NCH-1:0] load;
        logic [DW-1:0]  data;
    } seq_st_t;

    seq_st_t s_q, s_d;
    logic [NCH-1:0] scan_hot, first_hot;

    // Per-channel strobe decode for the scan pointer and the direct target.
    for (genvar g = 0; g < NCH; g++) begin : g_dec
        assign scan_hot[g]  = (s_q.ch == CHW'(g));
        assign first_hot[g] = (first_ch == CHW'(g));
    end

    always_comb begin
        s_d      = s_q;
        s_d.load = '0;
        pop      = 1'b0;

        if (disarm)       s_d.armed = 1'b0;
        else if (arm_evt) s_d.armed = 1'b1;

        if (s_q.active) begin
            pop = 1'b1;
            if (!fifo_empty) begin
                s_d.load = scan_hot;
                s_d.data = fifo_head;
            end
            if (s_q.ch == s_q.last) s_d.active = 1'b0;
            else                    s_d.ch     = s_q.ch + CHW'(1);
        end else if (direct_wr) begin
            s_d.load = first_hot;
            s_d.data = direct_data;
        end else if (tick && s_q.armed && !hold) begin
            s_d.active = 1'b1;
            s_d.ch     = first_ch;
            s_d.last   = (last_ch >= first_ch) ? last_ch : first_ch;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy     = s_q.active;
    assign dac_load = s_q.load;
    assign dac_data = s_q.data;

endmodule

// File: rtl/dac_host_regs.sv
`timescale 1ns/1ps
module dac_host_regs
    import dac_pacer_pkg::*;
#(
    parameter int DW  = 12,
    parameter int CHW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     bus_addr,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [7:0]     bus_wdata,
    output logic [7:0]     bus_rdata,
    input  logic           fifo_empty,
    input  logic           fifo_half,
    input  logic           fifo_err,
    input  logic           half_evt,
    output logic           push,
    output logic           direct_wr,
    output logic [DW-1:0]  sample,
    output logic           fifo_clr,
    output logic [CHW-1:0] first_ch,
    output logic [CHW-1:0] last_ch,
    output logic           hold,
    output logic           irq
);

    localparam int LOW_W = DW - 8;

    typedef struct packed {
        logic [LOW_W-1:0] lsb;
        logic [CHW-1:0]   first;
        logic [CHW-1:0]   last;
        logic             inte;
        logic [2:0]       lvl;
        logic             hold;
        logic             intst;
    } reg_st_t;

    reg_st_t  s_q, s_d;
    reg_ofs_e ofs;
    logic     wr_lsb, wr_msb, wr_chan, wr_ctrl, rd_lsb, rd_msb;

    assign ofs = reg_ofs_e'(bus_addr);

    always_comb begin
        wr_lsb  = bus_wr && (ofs == OFS_LSB);
        wr_msb  = bus_wr && (ofs == OFS_MSB);
        wr_chan = bus_wr && (ofs == OFS_CHAN);
        wr_ctrl = bus_wr && (ofs == OFS_CTRL);
        rd_lsb  = bus_rd && (ofs == OFS_LSB);
        rd_msb  = bus_rd && (ofs == OFS_MSB);

        s_d = s_q;
        if (wr_lsb) s_d.lsb = bus_wdata[LOW_W-1:0];
        if (wr_chan) begin
            s_d.first = bus_wdata[CHAN_FIRST_POS +: CHW];
            s_d.last  = bus_wdata[CHAN_LAST_POS +: CHW];
        end
        if (wr_ctrl) begin
            s_d.inte = bus_wdata[CTRL_INTE_POS];
            s_d.lvl  = bus_wdata[CTRL_LVL_POS +: 3];
            s_d.hold = bus_wdata[CTRL_HOLD_POS];
        end
        if (half_evt)    s_d.intst = 1'b1;
        else if (rd_lsb) s_d.intst = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (ofs)
            OFS_CHAN: begin
                bus_rdata[CHAN_FIRST_POS +: CHW] = s_q.first;
                bus_rdata[CHAN_LAST_POS +: CHW]  = s_q.last;
            end
            OFS_CTRL: bus_rdata = {s_q.inte, s_q.lvl, fifo_empty, fifo_half, fifo_err, s_q.intst};
            default:  bus_rdata = '0;
        endcase
    end

    assign push      = wr_msb && !s_q.hold;
    assign direct_wr = wr_msb && s_q.hold;
    assign sample    = {bus_wdata, s_q.lsb};
    assign fifo_clr  = rd_msb;
    assign first_ch  = s_q.first;
    assign last_ch   = s_q.last;
    assign hold      = s_q.hold;
    assign irq       = s_q.intst & s_q.inte;

endmodule

// File: rtl/dac_pacer_fifo_ctrl.sv
`timescale 1ns/1ps
module dac_pacer_fifo_ctrl #(
    parameter int NCH   = 4,
    parameter int DW    = 12,
    parameter int DEPTH = 1024
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     bus_addr,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [7:0]     bus_wdata,
    output logic [7:0]     bus_rdata,
    input  logic           pacer_tick,
    output logic [NCH-1:0] dac_load,
    output logic [DW-1:0]  dac_data,
    output logic           irq
);

    localparam int CHW = $clog2(NCH);
    localparam int CW  = $clog2(DEPTH + 1);

    logic           push, direct_wr, fifo_clr, hold, pop, scan_busy;
    logic [DW-1:0]  sample, fifo_head;
    logic [CHW-1:0] first_ch, last_ch;
    logic [CW-1:0]  fifo_count;
    logic           fifo_empty, fifo_half, fifo_err, half_evt, fill_evt;

    dac_host_regs #(.DW(DW), .CHW(CHW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .fifo_empty (fifo_empty),
        .fifo_half  (fifo_half),
        .fifo_err   (fifo_err),
        .half_evt   (half_evt),
        .push       (push),
        .direct_wr  (direct_wr),
        .sample     (sample),
        .fifo_clr   (fifo_clr),
        .first_ch   (first_ch),
        .last_ch    (last_ch),
        .hold       (hold),
        .irq        (irq)
    );

    dac_sample_fifo #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (fifo_clr),
        .push      (push),
        .push_data (sample),
        .pop       (pop),
        .head      (fifo_head),
        .count     (fifo_count),
        .empty     (fifo_empty),
        .half      (fifo_half),
        .err       (fifo_err),
        .half_evt  (half_evt),
        .fill_evt  (fill_evt)
    );

    dac_scan_seq #(.NCH(NCH), .DW(DW), .CHW(CHW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (pacer_tick),
        .hold        (hold),
        .arm_evt     (fill_evt),
        .disarm      (fifo_clr | hold),
        .first_ch    (first_ch),
        .last_ch     (last_ch),
        .fifo_empty  (fifo_empty),
        .fifo_head   (fifo_head),
        .direct_wr   (direct_wr),
        .direct_data (sample),
        .pop         (pop),
        .busy        (scan_busy),
        .dac_load    (dac_load),
        .dac_data    (dac_data)
    );

endmodule

// File: rtl/dac_pacer_fifo_chk.sv
`timescale 1ns/1ps
module dac_pacer_fifo_chk #(
    parameter int NCH   = 4,
    parameter int DEPTH = 1024,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_rd,
    input logic [1:0]     bus_addr,
    input logic [NCH-1:0] dac_load,
    input logic           irq,
    input logic           scan_busy,
    input logic           direct_wr,
    input logic           fifo_clr,
    input logic [CW-1:0]  fifo_count,
    input logic           fifo_err,
    input logic           half_evt
);

    AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dac_load)); // R3

    AST_LOAD_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_load != '0) |-> $past(scan_busy || direct_wr)); // R5

    AST_DIRECT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (direct_wr && !scan_busy) |=> (dac_load != '0)); // R5

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> (fifo_count == '0)); // R9

    AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd0 && !half_evt) |=> !irq); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_err && !fifo_clr) |=> fifo_err); // R10

    AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CW'(DEPTH)); // R10

endmodule

bind dac_pacer_fifo_ctrl dac_pacer_fifo_chk #(.NCH(NCH), .DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .dac_load   (dac_load),
    .irq        (irq),
    .scan_busy  (scan_busy),
    .direct_wr  (direct_wr),
    .fifo_clr   (fifo_clr),
    .fifo_count (fifo_count),
    .fifo_err   (fifo_err),
    .half_evt   (half_evt)
);

// File: tb/dac_pacer_fifo_ctrl_tb.sv
`timescale 1ns/1ps
module dac_pacer_fifo_ctrl_tb;

    localparam int NCH   = 4;
    localparam int DW    = 12;
    localparam int DEPTH = 1024;
    localparam int HALF  = 512;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [1:0]     bus_addr = '0;
    logic           bus_wr = 1'b0;
    logic           bus_rd = 1'b0;
    logic [7:0]     bus_wdata = '0;
    logic [7:0]     bus_rdata;
    logic           pacer_tick = 1'b0;
    logic [NCH-1:0] dac_load;
    logic [DW-1:0]  dac_data;
    logic           irq;

    always #10 clk = ~clk;

    dac_pacer_fifo_ctrl #(.NCH(NCH), .DW(DW), .DEPTH(DEPTH)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pacer_tick (pacer_tick),
        .dac_load   (dac_load),
        .dac_data   (dac_data),
        .irq        (irq)
    );

    int errors = 0;
    int checks = 0;
    int loads_seen = 0;
    logic [NCH-1:0] last_load = '0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int   mq[$];
    logic [3:0] m_lsb;
    int   m_first, m_last_ch, m_lvl, m_ch, m_stop, m_load, m_data;
    bit   m_inte, m_hold, m_intst, m_err, m_armed, m_active;

    always @(posedge clk) begin : model
        int  old, ld, dat;
        bit  clr, push, dwr, pushok, popok, half_evt, fill_evt;
        if (!rst_n) begin
            mq.delete();
            m_lsb = '0; m_first = 0; m_last_ch = 0; m_lvl = 0; m_ch = 0; m_stop = 0;
            m_load = 0; m_data = 0; m_inte = 0; m_hold = 0; m_intst = 0;
            m_err = 0; m_armed = 0; m_active = 0;
        end else begin
            old  = mq.size();
            clr  = bus_rd && bus_addr == 2'd1;
            push = bus_wr && bus_addr == 2'd1 && !m_hold;
            dwr  = bus_wr && bus_addr == 2'd1 && m_hold;
            ld   = 0;
            dat  = m_data;
            if (m_active && old > 0) begin
                ld  = 1 << m_ch;
                dat = mq[0];
            end
            half_evt = 0;
            fill_evt = 0;
            if (clr) begin
                mq.delete();
                m_err = 0;
            end else begin
                pushok = push && old < DEPTH;
                popok  = m_active && old > 0;
                if ((push && !pushok) || (m_active && old == 0)) m_err = 1;
                if (popok) void'(mq.pop_front());
                if (pushok) mq.push_back({bus_wdata, m_lsb});
                fill_evt = pushok && old == DEPTH - 1;
                half_evt = old > HALF && mq.size() == HALF;
            end
            if (m_active) begin
                if (m_ch == m_stop) m_active = 0;
                else m_ch++;
            end else if (dwr) begin
                ld  = 1 << m_first;
                dat = {bus_wdata, m_lsb};
            end else if (pacer_tick && m_armed && !m_hold) begin
                m_active = 1;
                m_ch     = m_first;
                m_stop   = (m_last_ch >= m_first) ? m_last_ch : m_first;
            end
            if (clr || m_hold) m_armed = 0;
            else if (fill_evt) m_armed = 1;
            if (half_evt) m_intst = 1;
            else if (bus_rd && bus_addr == 2'd0) m_intst = 0;
            if (bus_wr) begin
                case (bus_addr)
                    2'd0: m_lsb = bus_wdata[3:0];
                    2'd2: begin m_first = bus_wdata[1:0]; m_last_ch = bus_wdata[5:4]; end
                    2'd3: begin m_inte = bus_wdata[7]; m_lvl = bus_wdata[6:4]; m_hold = bus_wdata[0]; end
                    default: ;
                endcase
            end
            m_load = ld;
            m_data = dat;
        end
    end

    function automatic logic [7:0] model_rdata(input logic [1:0] a);
        logic [2:0] lv;
        lv = m_lvl[2:0];
        case (a)
            2'd2:    return 8'((m_last_ch << 4) | m_first);
            2'd3:    return {m_inte, lv, mq.size() == 0, mq.size() >= HALF, m_err, m_intst};
            default: return 8'h00;
        endcase
    endfunction

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check("R3", 32'(dac_load), 32'(m_load), "load strobes vs model");
            if (m_load != 0) check("R1", 32'(dac_data), 32'(m_data), "dac data vs model");
            check("R8", 32'(irq), 32'(m_intst && m_inte), "irq vs model");
            if (dac_load != '0) begin
                loads_seen++;
                last_load = dac_load;
            end
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d, output logic [7:0] e);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        d = bus_rdata;
        e = model_rdata(a);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic push_sample(input int s);
        bus_write(2'd0, 8'(s & 4'hF));
        bus_write(2'd1, 8'((s >> 4) & 8'hFF));
    endtask

    task automatic tick_once();
        @(negedge clk);
        pacer_tick = 1'b1;
        @(negedge clk);
        pacer_tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    function automatic int pat_a(input int i);
        return (i * 37 + 5) & 12'hFFF;
    endfunction

    function automatic int pat_b(input int i);
        return (i * 91 + 300) & 12'hFFF;
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [7:0] rd, ex;
        int base;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R11: reset state
        check("R11", 32'(dac_load), 32'h0, "load after reset");
        check("R11", 32'(irq), 32'h0, "irq after reset");
        bus_read(2'd3, rd, ex);
        check("R11", 32'(rd), 32'h08, "status after reset");
        bus_read(2'd2, rd, ex);
        check("R11", 32'(rd), 32'h00, "window after reset");

        // R6: window readback, unused bits read zero
        bus_write(2'd2, 8'hF1);
        bus_read(2'd2, rd, ex);
        check("R6", 32'(rd), 32'h31, "window readback");

        // R7: control fields read back through status
        bus_write(2'd3, 8'hD1);
        bus_read(2'd3, rd, ex);
        check("R7", 32'(rd), 32'hD8, "status with control fields");
        bus_read(2'd0, rd, ex);
        check("R7", 32'(rd), 32'h00, "offset 0 reads zero");

        // R5 and R1: direct transfer to the first channel
        bus_write(2'd0, 8'h0A);
        bus_write(2'd1, 8'h5C);
        check("R5", 32'(dac_load), 32'h2, "direct load strobe");
        check("R1", 32'(dac_data), 32'h5CA, "direct sample assembly");
        bus_read(2'd3, rd, ex);
        check("R5", 32'(rd), 32'hD8, "fifo untouched by direct write");
        base = loads_seen;
        tick_once();
        idle(5);
        check("R5", 32'(loads_seen - base), 32'h0, "tick ignored while held");

        // R2: paced mode waits for a full FIFO
        bus_write(2'd3, 8'hB0);
        bus_write(2'd2, 8'h30);
        for (int i = 0; i < DEPTH - 1; i++) push_sample(pat_a(i));
        base = loads_seen;
        tick_once();
        idle(6);
        check("R2", 32'(loads_seen - base), 32'h0, "no pacing before full");
        bus_read(2'd3, rd, ex);
        check("R7", 32'(rd), 32'hB4, "half flag set, not empty");
        push_sample(pat_a(DEPTH - 1));

        // R3: ascending scan with FIFO order
        tick_once();
        for (int k = 0; k < NCH; k++) begin
            @(negedge clk);
            check("R3", 32'(dac_load), 32'(1 << k), "scan channel order");
            check("R3", 32'(dac_data), 32'(pat_a(k)), "scan data order");
        end
        idle(2);

        // R3: a tick during a running scan is ignored
        base = loads_seen;
        @(negedge clk); pacer_tick = 1'b1;
        @(negedge clk);
        @(negedge clk); pacer_tick = 1'b0;
        idle(8);
        check("R3", 32'(loads_seen - base), 32'h4, "second tick ignored");

        // R8: interrupt at the half-way crossing (1016 -> 516 -> 512)
        repeat (125) begin
            tick_once();
            idle(4);
        end
        check("R8", 32'(irq), 32'h0, "no irq above half");
        tick_once();
        idle(5);
        check("R8", 32'(irq), 32'h1, "irq at half");
        bus_read(2'd3, rd, ex);
        check("R8", 32'(rd), 32'hB5, "pending bit in status");
        bus_read(2'd0, rd, ex);
        #1;
        check("R8", 32'(irq), 32'h0, "irq cleared by acknowledge");

        // R4: reversed window loads the first channel only
        bus_write(2'd2, 8'h12);
        base = loads_seen;
        tick_once();
        idle(5);
        check("R4", 32'(loads_seen - base), 32'h1, "reversed window count");
        check("R4", 32'(last_load), 32'h4, "reversed window channel");
        bus_write(2'd2, 8'h33);
        base = loads_seen;
        tick_once();
        idle(5);
        check("R4", 32'(loads_seen - base), 32'h1, "single channel count");
        check("R4", 32'(last_load), 32'h8, "single channel target");

        // R10: underflow (510 left -> 127 ticks leave 2, then one more)
        bus_write(2'd2, 8'h30);
        repeat (127) begin
            tick_once();
            idle(4);
        end
        base = loads_seen;
        tick_once();
        idle(6);
        check("R10", 32'(loads_seen - base), 32'h2, "no strobe on empty pop");
        bus_read(2'd3, rd, ex);
        check("R10", 32'(rd), 32'hBA, "error after underflow");

        // R9: flush empties, clears error and disarms
        bus_read(2'd1, rd, ex);
        bus_read(2'd3, rd, ex);
        check("R9", 32'(rd), 32'hB8, "status after flush");
        for (int i = 0; i < 4; i++) push_sample(pat_b(i));
        base = loads_seen;
        tick_once();
        idle(6);
        check("R9", 32'(loads_seen - base), 32'h0, "pacing disarmed by flush");

        // R10: overflow drops the sample and sets the error
        for (int i = 4; i < DEPTH; i++) push_sample(pat_b(i));
        push_sample(12'hABC);
        bus_read(2'd3, rd, ex);
        check("R10", 32'(rd), 32'hB6, "error after overflow");
        tick_once();
        for (int k = 0; k < NCH; k++) begin
            @(negedge clk);
            check("R10", 32'(dac_data), 32'(pat_b(k)), "queue intact after drop");
        end
        idle(4);
        bus_read(2'd3, rd, ex);
        check("R7", 32'(rd), 32'(ex), "status vs model");

        finish_run();
    end

endmodule